// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits between a simple host request port and a 4M x 16 EDO DRAM. The host presents a 22-bit word address, a two-bit byte enable, write data and a request strobe. The controller splits the address into a 12-bit row and a 10-bit column and sends them one after the other on a shared address bus. The row is latched by the falling row strobe and the column by the falling column strobes. There are two column strobes, one for each byte lane. Read data is captured a set number of cycles after the column strobes fall. It is handed back with a one-cycle valid pulse, and disabled byte lanes read as zero.

After an access the row stays open with the row strobe held low. A later access to the same row cycles only the column strobes (page mode). An access to a different row first raises the row strobe and waits out the precharge time. A free-running timer asks for a refresh at a fixed interval. The controller serves it ahead of any new request: it closes an open row, lowers both column strobes and then lowers the row strobe. Every delay is a whole number of clock cycles set by a parameter.

Top module: `edo_dram_ctrl`

## Requirements
- R1: After reset, the row strobe, both column strobes and write enable are high (inactive), `req_ready` is high and `rd_valid` is low.
- R2: When no row is open, the row strobe falls with `dram_addr` equal to `req_addr[21:10]`. At least T_RCD cycles later the column strobes fall with `dram_addr[9:0]` equal to `req_addr[9:0]` and `dram_addr[11:10]` zero. The column strobes only fall for data while the row strobe is low.
- R3: `req_be[0]` lowers `dram_casl_n` (bits 7:0) and `req_be[1]` lowers `dram_cash_n` (bits 15:8). With both bits set, both strobes fall in the same cycle.
- R4: During a write, `dram_we_n` is low and `dram_dq_oe` is high while the strobes are low, and `dram_dq_out` carries the write data. A byte whose enable bit is 0 is left unchanged in memory.
- R5: A read returns `rd_data` with each disabled byte lane forced to zero and `rd_valid` high for exactly one cycle.
- R6: An access to the row that is still open causes no new fall of the row strobe.
- R7: An access to a different row raises the row strobe and keeps it high for at least T_RP cycles before the new row is opened.
- R8: A refresh lowers both column strobes at least one cycle before the row strobe falls. Successive refreshes are no more than REF_INTERVAL cycles apart, plus the length of one access in flight.
- R9: A due refresh is served before any new request. It closes an open row first, so the next access after a refresh opens its row again.
- R10: `req_ready` is low from the cycle after a request is accepted until that access has finished. A request is taken only in a cycle where `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in bits 21:10, column in bits 9:0 |
| req_be | input | 2 | Byte enables, bit 0 lower byte, bit 1 upper byte |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Controller can accept a request |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data, disabled lanes zero |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Lower-byte column strobe, active low |
| dram_cash_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 16 | Data to the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from the memory |

## Verification
The assertions assume that the host holds `req_valid` and its fields steady only in a cycle where it sees `req_ready` high, and then drops the strobe. They also assume that at least one byte-enable bit is set in every request. The bench drives requests only after seeing `req_ready` high at a falling edge and removes them after one rising edge. Its random byte enables are drawn from the three non-zero values. Addresses come from a small pool of rows, including the first and last row, so that page hits, row misses and refresh-forced reopens all occur often.

// File: rtl/edo_pkg.sv
package edo_pkg;
   typedef enum logic [2:0] {
      S_IDLE    = 3'd0,
      S_ACT     = 3'd1,
      S_CAS     = 3'd2,
      S_PRE     = 3'd3,
      S_REF_CAS = 3'd4,
      S_REF_RAS = 3'd5,
      S_REF_PRE = 3'd6
   } edo_state_e;
endpackage

// File: rtl/edo_refresh_tmr.sv
module edo_refresh_tmr #(
   parameter int INTERVAL = 1950
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pending
);
   localparam int CW = $clog2(INTERVAL + 1);

   generate
      if (INTERVAL < 16) begin : g_bad_interval
         $error("refresh interval too short");
      end
   endgenerate

   logic [CW-1:0] tick;
   logic          wrap;

   assign wrap = (tick == CW'(INTERVAL - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick    <= '0;
         pending <= 1'b0;
      end else begin
         tick <= wrap ? '0 : tick + 1'b1;
         if (wrap)     pending <= 1'b1;
         else if (ack) pending <= 1'b0;
      end
   end

   // a due refresh stays requested until the controller starts it
   p_pending_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pending && !ack |=> pending);
endmodule

// File: rtl/edo_open_row.sv
module edo_open_row #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_set,
   input  logic             close,
   input  logic [ROW_W-1:0] row_in,
   input  logic [ROW_W-1:0] cmp_row,
   output logic             is_open,
   output logic [ROW_W-1:0] row_q,
   output logic             hit
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         row_q   <= '0;
      end else if (close) begin
         is_open <= 1'b0;
      end else if (open_set) begin
         is_open <= 1'b1;
         row_q   <= row_in;
      end
   end

   assign hit = is_open && (row_q == cmp_row);

   // a row being closed never reports a hit on the next cycle
   p_closed_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      close |=> !hit);
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
   parameter int ROW_W        = 12,
   parameter int COL_W        = 10,
   parameter int DATA_W       = 16,
   parameter int TIMER_W      = 8,
   parameter int T_RCD        = 2,
   parameter int T_CAS        = 3,
   parameter int T_CAC        = 2,
   parameter int T_RP         = 2,
   parameter int T_RAS_REF    = 4,
   parameter int REF_INTERVAL = 1950
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic [ROW_W+COL_W-1:0] req_addr,
   input  logic [DATA_W/8-1:0]    req_be,
   input  logic [DATA_W-1:0]      req_wdata,
   output logic                   req_ready,
   output logic                   rd_valid,
   output logic [DATA_W-1:0]      rd_data,
   output logic [ROW_W-1:0]       dram_addr,
   output logic                   dram_ras_n,
   output logic                   dram_casl_n,
   output logic                   dram_cash_n,
   output logic                   dram_we_n,
   output logic [DATA_W-1:0]      dram_dq_out,
   output logic                   dram_dq_oe,
   input  logic [DATA_W-1:0]      dram_dq_in
);
   import edo_pkg::*;

   localparam int LANES     = DATA_W / 8;
   localparam int SAMPLE_AT = T_CAS - T_CAC;
   localparam int T_MAX     = (T_RAS_REF > T_CAS) ? T_RAS_REF : T_CAS;

   generate
      if (DATA_W != 16)            begin : g_bad_width  $error("two byte strobes need DATA_W 16"); end
      if (COL_W > ROW_W)           begin : g_bad_col    $error("column wider than address bus"); end
      if (T_CAC < 1 || T_CAC > T_CAS) begin : g_bad_cac $error("T_CAC must be 1..T_CAS"); end
      if (T_RCD < 1 || T_RP < 1 || T_RAS_REF < 1) begin : g_bad_t $error("timings must be >= 1"); end
      if (T_MAX >= (1 << TIMER_W) || T_RCD >= (1 << TIMER_W) || T_RP >= (1 << TIMER_W))
         begin : g_bad_tw $error("TIMER_W too small"); end
   endgenerate

   edo_state_e         state;
   logic [TIMER_W-1:0] cnt;
   logic               after_ref;
   logic [ROW_W-1:0]   lat_row;
   logic [COL_W-1:0]   lat_col;
   logic [LANES-1:0]   lat_be;
   logic               lat_wr;
   logic [DATA_W-1:0]  lat_wdata;
   logic [DATA_W-1:0]  rd_masked;
   logic [ROW_W-1:0]   col_on_bus;

   logic ref_pending, ref_ack;
   logic row_open, row_hit, row_set, row_close;
   logic [ROW_W-1:0] open_row_q;

   assign ref_ack   = (state == S_REF_CAS);
   assign row_set   = (state == S_ACT);
   assign row_close = (state == S_PRE);

   edo_refresh_tmr #(.INTERVAL(REF_INTERVAL)) u_ref (
      .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pending(ref_pending));

   edo_open_row #(.ROW_W(ROW_W)) u_row (
      .clk(clk), .rst_n(rst_n), .open_set(row_set), .close(row_close),
      .row_in(lat_row), .cmp_row(req_addr[ROW_W+COL_W-1:COL_W]),
      .is_open(row_open), .row_q(open_row_q), .hit(row_hit));

   // column onto the shared bus, padded when the bus is wider
   generate
      if (ROW_W > COL_W) begin : g_col_pad
         assign col_on_bus = {{(ROW_W-COL_W){1'b0}}, lat_col};
      end else begin : g_col_full
         assign col_on_bus = lat_col;
      end
   endgenerate

   // per-lane read masking
   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         assign rd_masked[ln*8 +: 8] = lat_be[ln] ? dram_dq_in[ln*8 +: 8] : 8'h00;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         cnt       <= '0;
         after_ref <= 1'b0;
         lat_row   <= '0;
         lat_col   <= '0;
         lat_be    <= '0;
         lat_wr    <= 1'b0;
         lat_wdata <= '0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
      end else begin
         rd_valid <= 1'b0;
         unique case (state)
            S_IDLE: begin
               if (ref_pending) begin
                  after_ref <= 1'b1;
                  if (row_open) begin
                     state <= S_PRE;
                     cnt   <= TIMER_W'(T_RP - 1);
                  end else begin
                     state <= S_REF_CAS;
                  end
               end else if (req_valid) begin
                  after_ref <= 1'b0;
                  lat_row   <= req_addr[ROW_W+COL_W-1:COL_W];
                  lat_col   <= req_addr[COL_W-1:0];
                  lat_be    <= req_be;
                  lat_wr    <= req_write;
                  lat_wdata <= req_wdata;
                  if (row_hit) begin
                     state <= S_CAS;
                     cnt   <= TIMER_W'(T_CAS - 1);
                  end else if (row_open) begin
                     state <= S_PRE;
                     cnt   <= TIMER_W'(T_RP - 1);
                  end else begin
                     state <= S_ACT;
                     cnt   <= TIMER_W'(T_RCD - 1);
                  end
               end
            end
            S_ACT: begin
               if (cnt == '0) begin
                  state <= S_CAS;
                  cnt   <= TIMER_W'(T_CAS - 1);
               end else cnt <= cnt - 1'b1;
            end
            S_CAS: begin
               if (!lat_wr && cnt == TIMER_W'(SAMPLE_AT)) begin
                  rd_data  <= rd_masked;
                  rd_valid <= 1'b1;
               end
               if (cnt == '0) state <= S_IDLE;
               else cnt <= cnt - 1'b1;
            end
            S_PRE: begin
               if (cnt == '0) begin
                  if (after_ref) state <= S_REF_CAS;
                  else begin
                     state <= S_ACT;
                     cnt   <= TIMER_W'(T_RCD - 1);
                  end
               end else cnt <= cnt - 1'b1;
            end
            S_REF_CAS: begin
               state <= S_REF_RAS;
               cnt   <= TIMER_W'(T_RAS_REF - 1);
            end
            S_REF_RAS: begin
               if (cnt == '0) begin
                  state <= S_REF_PRE;
                  cnt   <= TIMER_W'(T_RP - 1);
               end else cnt <= cnt - 1'b1;
            end
            S_REF_PRE: begin
               if (cnt == '0) state <= S_IDLE;
               else cnt <= cnt - 1'b1;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   logic ref_cas_low, data_cas;
   assign ref_cas_low = (state == S_REF_CAS) || (state == S_REF_RAS);
   assign data_cas    = (state == S_CAS);

   assign req_ready   = (state == S_IDLE) && !ref_pending;
   assign dram_ras_n  = !((state == S_IDLE && row_open) || state == S_ACT ||
                          data_cas || state == S_REF_RAS);
   assign dram_casl_n = !((data_cas && lat_be[0]) || ref_cas_low);
   assign dram_cash_n = !((data_cas && lat_be[1]) || ref_cas_low);
   assign dram_we_n   = !(data_cas && lat_wr);
   assign dram_dq_oe  = data_cas && lat_wr;
   assign dram_dq_out = lat_wdata;
   assign dram_addr   = data_cas ? col_on_bus :
                        (state == S_IDLE ? open_row_q : lat_row);

   // R10: an accepted request makes the block busy on the next cycle
   p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);
   // R5: read data valid is a single-cycle pulse
   p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   // R7: the row strobe stays high at least one cycle after it rises
   p_precharge_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_ras_n) |=> dram_ras_n);
   // R8: a row-strobe fall under a low column strobe is a refresh with both strobes low beforehand
   p_cbr_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) && !dram_casl_n |-> !dram_cash_n && $past(!dram_casl_n));
   // R2: data writes happen only inside an open row
   p_write_in_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_we_n |-> !dram_ras_n && (!dram_casl_n || !dram_cash_n));
   // R4: write data is driven whenever write enable is low
   p_we_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_we_n |-> dram_dq_oe);
endmodule

// File: tb/edo_dram_ctrl_tb.sv
module edo_dram_ctrl_tb;
   localparam int T_RCD = 2, T_CAS = 3, T_CAC = 2, T_RP = 2, T_RAS_REF = 4;
   localparam int REF_IV = 200;
   localparam int REF_SLACK = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [21:0] req_addr = '0;
   logic [1:0]  req_be = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready, rd_valid;
   logic [15:0] rd_data;
   logic [11:0] dram_addr;
   logic        dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_dq_oe;
   logic [15:0] dram_dq_out;
   logic [15:0] dram_dq_in = '0;

   always #4 clk = ~clk;

   edo_dram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CAC(T_CAC), .T_RP(T_RP),
                   .T_RAS_REF(T_RAS_REF), .REF_INTERVAL(REF_IV)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_casl_n(dram_casl_n),
      .dram_cash_n(dram_cash_n), .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out),
      .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

   int n_tests = 0, n_fail = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] init_word(input logic [21:0] a);
      return a[15:0] ^ 16'hA5C3;
   endfunction

   // ---------------- memory model (sampled at falling edges) ----------------
   logic [15:0] mem [int];
   logic [15:0] exp_mem [int];
   logic [11:0] m_row = '0;
   bit   p_ras = 1, p_casl = 1, p_cash = 1;
   int   cyc = 0, opens = 0, refs = 0, cas_ev = 0;
   int   last_open_cyc = 0, ras_high_run = 0, last_ref_cyc = 0;
   logic [21:0] cas_addr;
   logic [1:0]  cas_lanes;
   bit   cas_we;
   int   cas_gap;
   bit   in_op = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (p_ras && !dram_ras_n) begin
            if (!dram_casl_n || !dram_cash_n) begin
               refs++;
               check(!dram_casl_n && !dram_cash_n && !p_casl && !p_cash, "R8 cbr strobes",
                     {dram_casl_n, dram_cash_n, p_casl, p_cash}, 0);
               check(cyc - last_ref_cyc <= REF_IV + REF_SLACK, "R8 refresh interval",
                     cyc - last_ref_cyc, REF_IV + REF_SLACK);
               check(!in_op, "R9 refresh during access", in_op, 0);
               last_ref_cyc = cyc;
            end else begin
               opens++;
               m_row = dram_addr;
               last_open_cyc = cyc;
            end
            check(ras_high_run >= T_RP, "R7 precharge time", ras_high_run, T_RP);
         end
         if (!dram_ras_n && ((p_casl && !dram_casl_n) || (p_cash && !dram_cash_n))) begin
            cas_ev++;
            cas_addr  = {m_row, dram_addr[9:0]};
            cas_lanes = {!dram_cash_n, !dram_casl_n};
            cas_we    = !dram_we_n;
            cas_gap   = cyc - last_open_cyc;
            check(dram_addr[11:10] == 2'b00, "R2 column pad bits", dram_addr[11:10], 0);
            if (!dram_we_n) begin
               logic [15:0] w;
               w = mem.exists(int'(cas_addr)) ? mem[int'(cas_addr)] : init_word(cas_addr);
               if (!dram_casl_n) w[7:0]  = dram_dq_out[7:0];
               if (!dram_cash_n) w[15:8] = dram_dq_out[15:8];
               mem[int'(cas_addr)] = w;
               check(dram_dq_oe, "R4 data driven", dram_dq_oe, 1);
            end else begin
               dram_dq_in <= mem.exists(int'(cas_addr)) ? mem[int'(cas_addr)] : init_word(cas_addr);
            end
         end
      end
      ras_high_run = dram_ras_n ? ras_high_run + 1 : 0;
      p_ras = dram_ras_n; p_casl = dram_casl_n; p_cash = dram_cash_n;
   end

   // ---------------- request driver and checks ----------------
   bit          b_open = 0;
   logic [11:0] b_row = '0;
   int          b_refs = 0;

   function automatic logic [15:0] exp_word(input logic [21:0] a);
      return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_word(a);
   endfunction

   task automatic access(input bit wr, input logic [21:0] a, input logic [1:0] be, input logic [15:0] d);
      int o0, c0;
      bit hit;
      logic [15:0] e;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      if (refs != b_refs) begin b_open = 0; b_refs = refs; end
      hit = b_open && (b_row == a[21:10]);
      o0 = opens; c0 = cas_ev;
      req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
      in_op = 1;
      @(negedge clk);
      req_valid = 0;
      check(!req_ready, "R10 ready drops", req_ready, 0);
      if (wr) begin
         while (!(cas_ev != c0 && dram_casl_n && dram_cash_n)) @(negedge clk);
      end else begin
         while (!rd_valid) @(negedge clk);
         e = exp_word(a);
         if (!be[0]) e[7:0] = 8'h00;
         if (!be[1]) e[15:8] = 8'h00;
         check(rd_data == e, "R5 read data", rd_data, e);
         @(negedge clk);
         check(!rd_valid, "R5 valid pulse width", rd_valid, 0);
      end
      in_op = 0;
      check(opens - o0 == (hit ? 0 : 1), hit ? "R6 page hit no reopen" : "R2 row opened once",
            opens - o0, hit ? 0 : 1);
      check(cas_addr == a, "R2 row/column address", cas_addr, a);
      check(cas_lanes == be, "R3 byte strobes", cas_lanes, be);
      check(cas_we == wr, "R4 write enable", cas_we, wr);
      if (!hit) check(cas_gap >= T_RCD, "R2 row-to-column delay", cas_gap, T_RCD);
      if (wr) begin
         e = exp_word(a);
         if (be[0]) e[7:0]  = d[7:0];
         if (be[1]) e[15:8] = d[15:8];
         exp_mem[int'(a)] = e;
      end
      b_open = 1; b_row = a[21:10];
   endtask

   function automatic logic [21:0] rnd_addr();
      logic [11:0] rows [4] = '{12'h000, 12'hFFF, 12'h5A3, 12'h0C7};
      logic [9:0] c;
      c = 10'($urandom % 8);
      if ($urandom % 2) c = c | 10'h3F8;
      return {rows[$urandom % 4], c};
   endfunction

   initial begin
      repeat (1000000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(dram_ras_n && dram_casl_n && dram_cash_n && dram_we_n, "R1 strobes idle",
            {dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n}, 4'hF);
      check(!rd_valid, "R1 no read valid", rd_valid, 0);
      rst_n = 1;
      @(negedge clk);
      check(req_ready, "R1 ready after reset", req_ready, 1);

      // directed corners
      access(1, {12'h000, 10'h000}, 2'b11, 16'h1234);   // miss, word write
      access(0, {12'h000, 10'h000}, 2'b11, 16'h0);      // page hit read
      access(1, {12'h000, 10'h000}, 2'b10, 16'hBEEF);   // upper byte only
      access(0, {12'h000, 10'h000}, 2'b11, 16'h0);      // lower byte must stay 34
      access(0, {12'h000, 10'h000}, 2'b01, 16'h0);      // upper lane reads zero
      access(1, {12'hFFF, 10'h3FF}, 2'b01, 16'h00AA);   // row miss, last address
      access(0, {12'hFFF, 10'h3FF}, 2'b11, 16'h0);
      // wait out a refresh, then reopen (R9)
      begin
         int r0;
         r0 = refs;
         while (refs == r0) @(negedge clk);
         access(0, {12'hFFF, 10'h3FF}, 2'b10, 16'h0);
         check(refs > r0, "R9 refresh then reopen", refs, r0 + 1);
      end

      for (int i = 0; i < 600; i++) begin
         logic [1:0] be;
         be = 2'(1 + ($urandom % 3));
         access(($urandom % 2) == 1, rnd_addr(), be, 16'($urandom));
      end

      check(refs >= 2, "R8 refreshes issued", refs, 2);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule